// File: doc/BRIEF.md
# Pipelined Memory Bus Request Sequencer

This block sits between an upstream pipeline that produces memory accesses and a simple local memory bus whose slave may take any number of cycles to answer. Each upstream request carries an address, a read/write flag, write data and a tag. The sequencer turns every request into one bus access. It marks the access with a single-cycle address strobe and keeps the read/write levels and write data steady until the slave answers with a ready pulse. It then hands the result back upstream as a one-cycle completion pulse that carries the request's tag and the captured read data.

A single parameter selects how closely accesses follow each other. In overlapped issue, the address of the next waiting request already appears on the bus while the current access is still waiting for ready. The next strobe is raised combinationally in the very cycle ready arrives, so a zero-wait slave can take one access per clock. In split issue, everything is registered: the cycle that carries ready never carries a strobe, and the next address appears only together with its own strobe. Only one access is ever outstanding in either mode.

Top module: `mbus_seq`

## Requirements
- R1: After reset, and whenever no access is outstanding and no request is offered, the block raises no strobe, no accept and no completion, and bus_rd and bus_wr are low.
- R2: Each access begins with bus_as high for exactly one cycle. In that cycle bus_addr equals the offered req_addr, and req_accept is high in that same cycle only.
- R3: At most one access is outstanding. While an access has not yet seen bus_ready, no new strobe is raised.
- R4: If bus_ready never arrives, the block stays stalled indefinitely and raises no further strobe or completion.
- R5: In overlapped issue (OVERLAP=1), from the cycle after a strobe, bus_addr shows the address of the next offered request even though ready has not yet arrived.
- R6: In overlapped issue, a cycle with bus_ready high and a request offered also carries that request's strobe. With a slave that needs W wait cycles, consecutive strobes of a continuous stream are W+1 cycles apart.
- R7: In split issue (OVERLAP=0), no strobe occurs in a cycle with bus_ready high. The next strobe comes one cycle later at the earliest, so consecutive strobes are W+2 cycles apart. bus_addr keeps the current access's address until the next strobe.
- R8: bus_rd, bus_wr and bus_wdata keep the values shown in the strobe cycle until the cycle in which bus_ready is seen. bus_wr=1 marks a write and bus_rd=1 marks a read.
- R9: One cycle after the ready cycle, done is high for exactly one cycle. It carries the access's tag, done_write, and, for reads, the bus_rdata sampled in the ready cycle. For writes done_rdata is zero. Completions come back in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Upstream request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_tag | input | TAG_W | Request tag returned with completion |
| req_accept | output | 1 | Request taken this cycle (its strobe is issued) |
| bus_as | output | 1 | Single-cycle address strobe |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Read level, held for the access |
| bus_wr | output | 1 | Write level, held for the access |
| bus_wdata | output | DATA_W | Write data, held for the access |
| bus_ready | input | 1 | Slave completion pulse |
| bus_rdata | input | DATA_W | Slave read data, valid with bus_ready |
| done | output | 1 | One-cycle completion pulse |
| done_write | output | 1 | Completed access was a write |
| done_tag | output | TAG_W | Tag of the completed access |
| done_rdata | output | DATA_W | Read data of the completed access |

## Verification
The bench builds two copies of the block side by side with the default widths, one with OVERLAP=1 and one with OVERLAP=0. Each copy is paired with a behavioural slave whose wait count is set to 0, 1 and 3 and which can also withhold ready indefinitely. Running the same request stream through both copies shows the difference in strobe spacing, W+1 against W+2. It also shows the ready-cycle strobe against the following-cycle strobe, and the pre-driven next address against the held current address. The indefinite hold exposes stall behaviour and level stability under a long wait.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    // Issue discipline selected per instance
    typedef enum logic {
        ISSUE_SPLIT   = 1'b0,
        ISSUE_OVERLAP = 1'b1
    } issue_mode_e;

    // Decide whether an offered request may start its access this cycle.
    // Overlapped issue may reuse the ready cycle of the running access;
    // split issue waits until nothing is outstanding.
    function automatic logic issue_ok(issue_mode_e mode, logic valid,
                                      logic busy, logic ready);
        logic slot_free;
        if (mode == ISSUE_OVERLAP)
            slot_free = !busy || ready;
        else
            slot_free = !busy;
        return valid && slot_free;
    endfunction

endpackage

// File: rtl/mbus_issue_ctl.sv
module mbus_issue_ctl
    import mbus_pkg::*;
#(
    parameter issue_mode_e MODE = ISSUE_OVERLAP
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic bus_ready,
    output logic issue,
    output logic busy,
    output logic fin
);

    logic busy_q;

    always_comb begin
        fin   = busy_q && bus_ready;
        issue = issue_ok(MODE, req_valid, busy_q, bus_ready);
    end

    always_ff @(posedge clk) begin
        if (rst)
            busy_q <= 1'b0;
        else if (issue)
            busy_q <= 1'b1;
        else if (fin)
            busy_q <= 1'b0;
    end

    assign busy = busy_q;

endmodule

// File: rtl/mbus_hold_regs.sv
module mbus_hold_regs
    import mbus_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 4,
    parameter issue_mode_e MODE   = ISSUE_OVERLAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              busy,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              cur_write,
    output logic [TAG_W-1:0]  cur_tag
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  tag;
    } access_t;

    access_t cur_q;
    access_t incoming;

    always_comb begin
        incoming.addr  = req_addr;
        incoming.wr    = req_write;
        incoming.wdata = req_wdata;
        incoming.tag   = req_tag;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= '0;
        else if (issue)
            cur_q <= incoming;
    end

    // Address presentation depends on the issue discipline
    generate
        if (MODE == ISSUE_OVERLAP) begin : g_predrive
            assign bus_addr = req_valid ? req_addr : cur_q.addr;
        end else begin : g_hold_addr
            assign bus_addr = issue ? req_addr : cur_q.addr;
        end
    endgenerate

    // Levels and data follow the access that owns the bus this cycle
    always_comb begin
        if (issue) begin
            bus_wr    = req_write;
            bus_rd    = !req_write;
            bus_wdata = req_wdata;
        end else begin
            bus_wr    = busy && cur_q.wr;
            bus_rd    = busy && !cur_q.wr;
            bus_wdata = cur_q.wdata;
        end
    end

    assign cur_write = cur_q.wr;
    assign cur_tag   = cur_q.tag;

endmodule

// File: rtl/mbus_return.sv
module mbus_return #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fin,
    input  logic              cur_write,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              done_write,
    output logic [TAG_W-1:0]  done_tag,
    output logic [DATA_W-1:0] done_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            done_write <= 1'b0;
            done_tag   <= '0;
            done_rdata <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                done_write <= cur_write;
                done_tag   <= cur_tag;
                done_rdata <= cur_write ? '0 : bus_rdata;
            end
        end
    end

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned TAG_W   = 4,
    parameter bit          OVERLAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              req_accept,
    output logic              bus_as,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic              done_write,
    output logic [TAG_W-1:0]  done_tag,
    output logic [DATA_W-1:0] done_rdata
);

    localparam issue_mode_e MODE = issue_mode_e'(OVERLAP);

    logic             issue_w;
    logic             busy_w;
    logic             fin_w;
    logic             cur_write_w;
    logic [TAG_W-1:0] cur_tag_w;

    mbus_issue_ctl #(
        .MODE (MODE)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .issue     (issue_w),
        .busy      (busy_w),
        .fin       (fin_w)
    );

    mbus_hold_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .MODE   (MODE)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue_w),
        .busy      (busy_w),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_tag   (req_tag),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cur_write (cur_write_w),
        .cur_tag   (cur_tag_w)
    );

    mbus_return #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_ret (
        .clk        (clk),
        .rst        (rst),
        .fin        (fin_w),
        .cur_write  (cur_write_w),
        .cur_tag    (cur_tag_w),
        .bus_rdata  (bus_rdata),
        .done       (done),
        .done_write (done_write),
        .done_tag   (done_tag),
        .done_rdata (done_rdata)
    );

    assign bus_as     = issue_w;
    assign req_accept = issue_w;

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter bit          OVERLAP = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_accept,
    input logic              bus_as,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready,
    input logic              done,
    input logic              busy
);

    // R1: quiet bus while idle with nothing offered
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |-> (!bus_as && !bus_rd && !bus_wr && !req_accept));

    // R2: strobe shows the offered address and takes the request
    a_r2_strobe_addr: assert property (@(posedge clk) disable iff (rst)
        bus_as |-> (bus_addr == req_addr) && req_accept && req_valid);

    // R3: no second strobe while the running access waits
    a_r3_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_ready) |-> !bus_as);

    // R4: without ready the access stays open and nothing completes
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_ready) |=> (busy && !done));

    // R8: levels and write data steady while waiting
    a_r8_levels_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_as) |-> ($stable(bus_wr) && $stable(bus_rd) && $stable(bus_wdata)));

    // R9: completion pulse follows the ready cycle, and only that
    a_r9_done_follows: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_ready) |=> done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        !(busy && bus_ready) |=> !done);

    generate
        if (OVERLAP) begin : g_ovl
            // R5: next offered address is on the bus during the wait
            a_r5_predrive: assert property (@(posedge clk) disable iff (rst)
                (busy && req_valid) |-> (bus_addr == req_addr));

            // R6: ready with a request offered carries the new strobe
            a_r6_ready_strobe: assert property (@(posedge clk) disable iff (rst)
                (busy && bus_ready && req_valid) |-> bus_as);
        end else begin : g_split
            // R7: never a strobe in a ready cycle
            a_r7_no_ready_strobe: assert property (@(posedge clk) disable iff (rst)
                bus_ready |-> !bus_as);

            // R7: address unchanged between strobes while an access runs
            a_r7_addr_held: assert property (@(posedge clk) disable iff (rst)
                (busy && !bus_as) |-> $stable(bus_addr));
        end
    endgenerate

endmodule

bind mbus_seq mbus_seq_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OVERLAP (OVERLAP)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_accept (req_accept),
    .bus_as     (bus_as),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_ready  (bus_ready),
    .done       (done),
    .busy       (busy_w)
);

// File: tb/mbus_wait_slave.sv
module mbus_wait_slave (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  wait_cfg,
    input  logic        hold,
    input  logic        bus_as,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic        bus_ready,
    output logic [31:0] bus_rdata,
    output logic        perr,
    output logic        herr
);

    logic [31:0] mem [16];
    logic        pend;
    logic [3:0]  cnt;
    logic [3:0]  lat_addr;
    logic        lat_we;
    logic [31:0] lat_wdata;

    assign bus_ready = pend && (cnt == 4'd0) && !hold;
    assign bus_rdata = bus_ready ? mem[lat_addr] : 32'h0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            cnt       <= 4'd0;
            lat_addr  <= 4'd0;
            lat_we    <= 1'b0;
            lat_wdata <= 32'h0;
            perr      <= 1'b0;
            herr      <= 1'b0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
        end else begin
            if (bus_ready && lat_we) mem[lat_addr] <= lat_wdata;
            if (pend && !bus_as &&
                ((bus_wr != lat_we) || (lat_we && bus_wdata != lat_wdata)))
                herr <= 1'b1;
            if (bus_as) begin
                if (pend && !bus_ready) perr <= 1'b1;
                pend      <= 1'b1;
                cnt       <= wait_cfg;
                lat_addr  <= bus_addr[3:0];
                lat_we    <= bus_wr;
                lat_wdata <= bus_wdata;
            end else if (bus_ready) begin
                pend <= 1'b0;
            end else if (pend && cnt != 4'd0) begin
                cnt <= cnt - 4'd1;
            end
        end
    end

endmodule

// File: tb/mbus_seq_test.sv
module mbus_seq_test;

    localparam int NV = 10;
    // {write, addr, wdata, tag, expected done_rdata}
    localparam logic [84:0] VEC [NV] = '{
        {1'b1, 16'h0003, 32'h1111_0003, 4'd1,  32'h0},
        {1'b1, 16'h0006, 32'h2222_0006, 4'd2,  32'h0},
        {1'b0, 16'h0003, 32'h0,         4'd3,  32'h1111_0003},
        {1'b1, 16'h000A, 32'h3333_000A, 4'd4,  32'h0},
        {1'b0, 16'h0006, 32'h0,         4'd5,  32'h2222_0006},
        {1'b0, 16'h000A, 32'h0,         4'd6,  32'h3333_000A},
        {1'b1, 16'h0003, 32'h4444_0003, 4'd7,  32'h0},
        {1'b0, 16'h0003, 32'h0,         4'd8,  32'h4444_0003},
        {1'b0, 16'h0006, 32'h0,         4'd9,  32'h2222_0006},
        {1'b1, 16'h000F, 32'h5555_000F, 4'd10, 32'h0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic        req_valid  [2];
    logic        req_write  [2];
    logic [15:0] req_addr   [2];
    logic [31:0] req_wdata  [2];
    logic [3:0]  req_tag    [2];
    logic        req_accept [2];
    logic        bus_as     [2];
    logic [15:0] bus_addr   [2];
    logic        bus_rd     [2];
    logic        bus_wr     [2];
    logic [31:0] bus_wdata  [2];
    logic        bus_ready  [2];
    logic [31:0] bus_rdata  [2];
    logic        done       [2];
    logic        done_write [2];
    logic [3:0]  done_tag   [2];
    logic [31:0] done_rdata [2];
    logic        perr       [2];
    logic        herr       [2];
    logic        hold       [2];
    logic [3:0]  wait_cfg;

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_dut
            mbus_seq #(.OVERLAP(gi == 0)) uut (
                .clk(clk), .rst(rst),
                .req_valid(req_valid[gi]), .req_write(req_write[gi]),
                .req_addr(req_addr[gi]), .req_wdata(req_wdata[gi]),
                .req_tag(req_tag[gi]), .req_accept(req_accept[gi]),
                .bus_as(bus_as[gi]), .bus_addr(bus_addr[gi]),
                .bus_rd(bus_rd[gi]), .bus_wr(bus_wr[gi]),
                .bus_wdata(bus_wdata[gi]), .bus_ready(bus_ready[gi]),
                .bus_rdata(bus_rdata[gi]), .done(done[gi]),
                .done_write(done_write[gi]), .done_tag(done_tag[gi]),
                .done_rdata(done_rdata[gi])
            );
            mbus_wait_slave u_slave (
                .clk(clk), .rst(rst), .wait_cfg(wait_cfg), .hold(hold[gi]),
                .bus_as(bus_as[gi]), .bus_addr(bus_addr[gi]),
                .bus_wr(bus_wr[gi]), .bus_wdata(bus_wdata[gi]),
                .bus_ready(bus_ready[gi]), .bus_rdata(bus_rdata[gi]),
                .perr(perr[gi]), .herr(herr[gi])
            );
        end
    endgenerate

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic        st_we    [NV];
    logic [15:0] st_addr  [NV];
    logic [31:0] st_wdata [NV];
    logic [3:0]  st_tag   [NV];
    logic [31:0] st_exp   [NV];
    int          scyc     [2][NV];

    task automatic chk(input bit ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic run_stream(input int k);
        int p = 0;
        while (p < NV) begin
            @(negedge clk);
            req_valid[k] = 1'b1;
            req_write[k] = st_we[p];
            req_addr[k]  = st_addr[p];
            req_wdata[k] = st_wdata[p];
            req_tag[k]   = st_tag[p];
            #1;
            if (req_accept[k]) begin
                chk(bus_as[k] && bus_addr[k] == st_addr[p], "R2 strobe address",
                    {47'd0, bus_as[k], bus_addr[k]}, {48'd1, st_addr[p]});
                scyc[k][p] = cyc;
                p++;
            end
        end
        @(negedge clk);
        req_valid[k] = 1'b0;
    endtask

    task automatic watch_done(input int k);
        int c = 0;
        while (c < NV) begin
            @(negedge clk);
            if (done[k]) begin
                chk(done_tag[k] == st_tag[c], "R9 completion tag order",
                    {60'd0, done_tag[k]}, {60'd0, st_tag[c]});
                chk(done_rdata[k] == st_exp[c] && done_write[k] == st_we[c],
                    "R9 completion data", {32'd0, done_rdata[k]}, {32'd0, st_exp[c]});
                c++;
            end
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n_as [2];
        wait_cfg = 4'd0;
        for (int k = 0; k < 2; k++) begin
            req_valid[k] = 1'b0; req_write[k] = 1'b0; req_addr[k] = '0;
            req_wdata[k] = '0;   req_tag[k] = '0;     hold[k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: quiet after reset with nothing offered
        repeat (3) begin
            @(negedge clk); #1;
            for (int k = 0; k < 2; k++)
                chk(!bus_as[k] && !req_accept[k] && !done[k] && !bus_rd[k] && !bus_wr[k],
                    "R1 idle after reset",
                    {59'd0, bus_as[k], req_accept[k], done[k], bus_rd[k], bus_wr[k]}, 64'd0);
        end

        // Table walk under several slave wait counts
        for (int wi = 0; wi < 3; wi++) begin
            int w;
            w = (wi == 0) ? 0 : ((wi == 1) ? 1 : 3);
            wait_cfg = 4'(w);
            for (int v = 0; v < NV; v++)
                {st_we[v], st_addr[v], st_wdata[v], st_tag[v], st_exp[v]} = VEC[v];
            fork
                run_stream(0);
                run_stream(1);
                watch_done(0);
                watch_done(1);
            join
            for (int p = 1; p < NV; p++) begin
                chk(scyc[0][p] - scyc[0][p-1] == w + 1, "R6 overlapped spacing",
                    64'(scyc[0][p] - scyc[0][p-1]), 64'(w + 1));
                chk(scyc[1][p] - scyc[1][p-1] == w + 2, "R7 split spacing",
                    64'(scyc[1][p] - scyc[1][p-1]), 64'(w + 2));
            end
            repeat (3) @(negedge clk);
        end

        // Directed stall: slave withholds ready
        wait_cfg = 4'd0;
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            hold[k] = 1'b1;
            req_valid[k] = 1'b1; req_write[k] = 1'b1; req_addr[k] = 16'h0005;
            req_wdata[k] = 32'hDEAD_0005; req_tag[k] = 4'd9;
        end
        #1;
        for (int k = 0; k < 2; k++)
            chk(bus_as[k] && req_accept[k] && bus_addr[k] == 16'h0005, "R2 first strobe",
                {46'd0, bus_as[k], req_accept[k], bus_addr[k]}, {46'd0, 2'b11, 16'h0005});
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            req_write[k] = 1'b0; req_addr[k] = 16'h0006;
            req_wdata[k] = 32'h0; req_tag[k] = 4'd10;
        end
        #1;
        for (int k = 0; k < 2; k++) begin
            chk(!bus_as[k] && !req_accept[k], "R3 no strobe while waiting",
                {62'd0, bus_as[k], req_accept[k]}, 64'd0);
            chk(bus_wr[k] && !bus_rd[k] && bus_wdata[k] == 32'hDEAD_0005, "R8 write held",
                {30'd0, bus_wr[k], bus_rd[k], bus_wdata[k]}, {30'd0, 2'b10, 32'hDEAD_0005});
        end
        chk(bus_addr[0] == 16'h0006, "R5 next address pre-driven",
            {48'd0, bus_addr[0]}, 64'h6);
        chk(bus_addr[1] == 16'h0005, "R7 address held until strobe",
            {48'd0, bus_addr[1]}, 64'h5);
        n_as[0] = 0; n_as[1] = 0;
        repeat (12) begin
            @(negedge clk); #1;
            for (int k = 0; k < 2; k++)
                if (bus_as[k] || done[k]) n_as[k]++;
        end
        for (int k = 0; k < 2; k++)
            chk(n_as[k] == 0, "R4 stalled without ready", 64'(n_as[k]), 64'd0);

        // Release ready
        @(negedge clk);
        hold[0] = 1'b0; hold[1] = 1'b0;
        #1;
        chk(bus_ready[0] && bus_as[0] && bus_addr[0] == 16'h0006, "R6 strobe in ready cycle",
            {46'd0, bus_ready[0], bus_as[0], bus_addr[0]}, {46'd0, 2'b11, 16'h0006});
        chk(bus_ready[1] && !bus_as[1], "R7 no strobe in ready cycle",
            {62'd0, bus_ready[1], bus_as[1]}, 64'b10);
        @(negedge clk);
        req_valid[0] = 1'b0;
        #1;
        for (int k = 0; k < 2; k++)
            chk(done[k] && done_write[k] && done_tag[k] == 4'd9 && done_rdata[k] == 32'h0,
                "R9 write completion", {27'd0, done[k], done_tag[k], done_rdata[k]},
                {27'd1, 4'd9, 32'h0});
        chk(bus_as[1] && bus_addr[1] == 16'h0006, "R7 strobe one cycle after ready",
            {47'd0, bus_as[1], bus_addr[1]}, {48'd1, 16'h0006});
        @(negedge clk);
        req_valid[1] = 1'b0;
        #1;
        chk(done[0] && !done_write[0] && done_tag[0] == 4'd10 && done_rdata[0] == 32'h2222_0006,
            "R9 read completion overlapped", {27'd0, done[0], done_tag[0], done_rdata[0]},
            {27'd1, 4'd10, 32'h2222_0006});
        chk(!done[1], "R9 single pulse split", {63'd0, done[1]}, 64'd0);
        @(negedge clk); #1;
        chk(done[1] && done_tag[1] == 4'd10 && done_rdata[1] == 32'h2222_0006,
            "R9 read completion split", {27'd0, done[1], done_tag[1], done_rdata[1]},
            {27'd1, 4'd10, 32'h2222_0006});
        chk(!done[0], "R9 single pulse overlapped", {63'd0, done[0]}, 64'd0);

        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(!perr[k], "R3 slave saw no overlapping access", {63'd0, perr[k]}, 64'd0);
            chk(!herr[k], "R8 slave saw steady levels", {63'd0, herr[k]}, 64'd0);
            chk(!bus_rd[k] && !bus_wr[k] && !bus_as[k], "R1 idle after traffic",
                {61'd0, bus_rd[k], bus_wr[k], bus_as[k]}, 64'd0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule